// File: doc/BRIEF.md
# Serial Control-Word Loader for a PLL Synthesiser

This block takes a synthesiser control word from a three-wire serial bus (data, shift clock, frame enable). While the frame enable is high, each rising edge of the shift clock moves one data bit into a shift register, most significant bit first. When the enable falls, a frame that holds exactly the configured number of bits is kept as a pending word. A frame of any other length is dropped.

The pending word is not copied to the outputs at once. It waits for a one-cycle boundary strobe from the programmable divider. The new divider ratio and the other settings therefore change only between divider cycles, which keeps fine tuning free of glitches.

All three bus lines are asynchronous. Each one passes through a two-flop synchroniser into the system clock domain, and edges are detected after the synchroniser. The parameter `LONG_FMT` selects the word format. The long format is 28 bits and has four switch-port bits. The short format is 26 bits and has two switch-port bits. The outputs are plain control levels with no handshake. The bus has no back-pressure, so a new frame can always arrive. If a newer frame arrives before the strobe, it replaces the pending word.

Top module: `synth_prog_port`

## Requirements
- R1: While the enable is high, each rising edge of the shift clock shifts in one bit, most significant bit first. The first bit sent becomes the top bit of the word.
- R2: Shift-clock edges that occur while the enable is low shift nothing and do not count toward the frame length.
- R3: A falling edge of the enable after exactly WLEN bits (28 for long, 26 for short) stores a pending word. The outputs keep their old values until a boundary strobe arrives.
- R4: A one-cycle `div_strobe` pulse while a word is pending copies that word to the outputs on the next clock edge and clears the pending state.
- R5: A frame with fewer or more bits than WLEN is discarded. A later strobe leaves the outputs unchanged.
- R6: If a second valid frame ends before the strobe, the strobe applies the second frame.
- R7: Long-format field positions, with bit 27 sent first:
  - ports [27:24]
  - prescaler enable [23]
  - divider ratio [22:6]
  - reference select [5:3]
  - charge pump current [2]
  - test mode [1]
  - drive disable [0]
- R8: The short format (`LONG_FMT=0`) has a 26-bit word. It has ports [25:24], and every other field sits at the same position as in R7.
- R9: After reset, every output is zero and nothing is pending.
- R10: A strobe with nothing pending leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_dat | input | 1 | Serial data, asynchronous |
| bus_clk | input | 1 | Serial shift clock, asynchronous |
| bus_en | input | 1 | Frame enable, asynchronous |
| div_strobe | input | 1 | Divider cycle boundary pulse |
| port_out | output | NPORT (4 or 2) | Switch-port levels |
| prescale_en | output | 1 | Divide-by-two prescaler enable |
| div_ratio | output | 17 | Programmable divider ratio |
| ref_sel | output | 3 | Reference divider ratio select |
| cp_hi | output | 1 | Charge pump current select |
| test_mode | output | 1 | Test mode bit |
| drive_off | output | 1 | Varactor drive disable |

## Verification
Assertions check these properties on every cycle:
- The shift register and bit counter stay frozen and cleared while the enable is low.
- The counter never passes its saturation value.
- The applied word changes only on a strobe taken while a word is pending.
- A load always leaves a pending word, and a strobe consumes it.

Only the bench scenarios can show the rest:
- Bit order and field placement.
- The rejection of short and long frames.
- The replacement of a pending word.
- The difference between the two word formats, which runs with both formats side by side on the same bus.

// File: rtl/synth_prog_pkg.sv
`timescale 1ns/1ps
package synth_prog_pkg;
  localparam int RATIO_W = 17;
  localparam int REF_W   = 3;
  localparam int CORE_W  = 1 + RATIO_W + REF_W + 3;

  typedef struct packed {
    logic               prescale_en;
    logic [RATIO_W-1:0] ratio;
    logic [REF_W-1:0]   ref_sel;
    logic               cp_hi;
    logic               test_mode;
    logic               drive_off;
  } core_cfg_t;
endpackage

// File: rtl/bus_sync.sv
`timescale 1ns/1ps
module bus_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/shift_rx.sv
`timescale 1ns/1ps
module shift_rx #(
  parameter int WLEN = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_s,
  input  logic            sclk_s,
  input  logic            sdat_s,
  output logic            load_req,
  output logic [WLEN-1:0] load_word
);
  localparam int CW = $clog2(WLEN + 2);
  localparam logic [CW-1:0] FULL = CW'(WLEN);
  localparam logic [CW-1:0] OVER = CW'(WLEN + 1);

  logic            en_d, sclk_d;
  logic [CW-1:0]   cnt;
  logic [WLEN-1:0] sr;
  logic            sclk_rise, en_fall;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign en_fall   = ~en_s & en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d   <= 1'b0;
      sclk_d <= 1'b0;
      cnt    <= '0;
      sr     <= '0;
    end else begin
      en_d   <= en_s;
      sclk_d <= sclk_s;
      if (!en_s) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        sr <= {sr[WLEN-2:0], sdat_s};
        if (cnt != OVER) cnt <= cnt + 1'b1;
      end
    end
  end

  assign load_req  = en_fall && (cnt == FULL);
  assign load_word = sr;

  assert_idle_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (cnt == '0));
  assert_idle_no_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> $stable(sr));
  assert_count_capped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= OVER);
endmodule

// File: rtl/cfg_hold.sv
`timescale 1ns/1ps
module cfg_hold #(
  parameter int WLEN = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_req,
  input  logic [WLEN-1:0] load_word,
  input  logic            div_strobe,
  output logic [WLEN-1:0] act_word
);
  logic [WLEN-1:0] pend;
  logic            pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      pend_v   <= 1'b0;
      act_word <= '0;
    end else begin
      if (div_strobe && pend_v) act_word <= pend;
      if (load_req) begin
        pend   <= load_word;
        pend_v <= 1'b1;
      end else if (div_strobe) begin
        pend_v <= 1'b0;
      end
    end
  end

  assert_apply_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_word != $past(act_word)) |-> $past(div_strobe && pend_v));
  assert_load_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> pend_v);
  assert_pending_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_strobe && pend_v && !load_req) |=> !pend_v);
endmodule

// File: rtl/synth_prog_port.sv
`timescale 1ns/1ps
module synth_prog_port
  import synth_prog_pkg::*;
#(
  parameter bit LONG_FMT = 1'b1,
  localparam int NPORT = LONG_FMT ? 4 : 2,
  localparam int WLEN  = NPORT + CORE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_dat,
  input  logic               bus_clk,
  input  logic               bus_en,
  input  logic               div_strobe,
  output logic [NPORT-1:0]   port_out,
  output logic               prescale_en,
  output logic [RATIO_W-1:0] div_ratio,
  output logic [REF_W-1:0]   ref_sel,
  output logic               cp_hi,
  output logic               test_mode,
  output logic               drive_off
);
  logic [2:0]      bus_s;
  logic            load_req;
  logic [WLEN-1:0] load_word, act_word;
  core_cfg_t       core;

  bus_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({bus_en, bus_clk, bus_dat}),
    .sync_out(bus_s)
  );

  shift_rx #(.WLEN(WLEN)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .en_s(bus_s[2]), .sclk_s(bus_s[1]), .sdat_s(bus_s[0]),
    .load_req(load_req), .load_word(load_word)
  );

  cfg_hold #(.WLEN(WLEN)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load_req(load_req), .load_word(load_word),
    .div_strobe(div_strobe), .act_word(act_word)
  );

  assign port_out    = act_word[WLEN-1 -: NPORT];
  assign core        = core_cfg_t'(act_word[CORE_W-1:0]);
  assign prescale_en = core.prescale_en;
  assign div_ratio   = core.ratio;
  assign ref_sel     = core.ref_sel;
  assign cp_hi       = core.cp_hi;
  assign test_mode   = core.test_mode;
  assign drive_off   = core.drive_off;

  assert_load_after_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> !bus_s[2]);
endmodule

// File: tb/test_synth_prog_port.sv
`timescale 1ns/1ps
module test_synth_prog_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_dat = 1'b0, bus_clk = 1'b0, bus_en = 1'b0, div_strobe = 1'b0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  logic [3:0] l_port;  logic l_pre; logic [16:0] l_ratio; logic [2:0] l_ref;
  logic l_cp, l_tm, l_off;
  logic [1:0] s_port;  logic s_pre; logic [16:0] s_ratio; logic [2:0] s_ref;
  logic s_cp, s_tm, s_off;

  synth_prog_port #(.LONG_FMT(1'b1)) i_synth_prog_port (
    .clk(clk), .rst_n(rst_n), .bus_dat(bus_dat), .bus_clk(bus_clk), .bus_en(bus_en),
    .div_strobe(div_strobe), .port_out(l_port), .prescale_en(l_pre), .div_ratio(l_ratio),
    .ref_sel(l_ref), .cp_hi(l_cp), .test_mode(l_tm), .drive_off(l_off));

  synth_prog_port #(.LONG_FMT(1'b0)) i_synth_prog_port_short (
    .clk(clk), .rst_n(rst_n), .bus_dat(bus_dat), .bus_clk(bus_clk), .bus_en(bus_en),
    .div_strobe(div_strobe), .port_out(s_port), .prescale_en(s_pre), .div_ratio(s_ratio),
    .ref_sel(s_ref), .cp_hi(s_cp), .test_mode(s_tm), .drive_off(s_off));

  wire [27:0] got_l = {l_port, l_pre, l_ratio, l_ref, l_cp, l_tm, l_off};
  wire [25:0] got_s = {s_port, s_pre, s_ratio, s_ref, s_cp, s_tm, s_off};

  logic [27:0] exp_l = '0;
  logic [25:0] exp_s = '0;

  localparam int NV = 7;
  localparam logic [28:0] VW [NV] = '{29'h0ABCDEF1, 29'h03FFFFFF, 29'h01234567,
                                      29'h1FFFFFFF, 29'h0FFFFFFF, 29'h00000001, 29'h05555555};
  localparam int VN [NV] = '{28, 26, 27, 29, 28, 26, 28};

  task automatic check(input string req, input logic [27:0] got, input logic [27:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_both(input string req);
    check({req, " long"}, got_l, exp_l);
    check({req, " short"}, {2'b0, got_s}, {2'b0, exp_s});
  endtask

  task automatic gap();
    repeat (8) @(negedge clk);
  endtask

  task automatic send(input logic [28:0] w, input int n);
    @(negedge clk) bus_en = 1'b1;
    gap();
    for (int i = n - 1; i >= 0; i--) begin
      bus_dat = w[i]; gap();
      bus_clk = 1'b1; gap();
      bus_clk = 1'b0;
    end
    gap();
    bus_en = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) div_strobe = 1'b1;
    @(negedge clk) div_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    check_both("R9 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    strobe();
    check_both("R10 strobe with nothing pending");

    // Vector table: R1 R3 R4 R5 R7 R8
    for (int v = 0; v < NV; v++) begin
      send(VW[v], VN[v]);
      check_both("R3 hold until strobe");
      strobe();
      if (VN[v] == 28) exp_l = VW[v][27:0];
      if (VN[v] == 26) exp_s = VW[v][25:0];
      check_both((VN[v] == 28 || VN[v] == 26) ? "R1 R7 R8 apply" : "R5 length mismatch");
    end

    // R7: single-field placement
    send(29'h0800040, 28); strobe(); exp_l = 28'h0800040;
    check("R7 prescaler and ratio lsb", got_l, exp_l);
    check("R7 ratio lsb field", {11'b0, l_ratio}, 28'h1);
    check("R7 prescaler bit", {27'b0, l_pre}, 28'h1);

    // R2: shift-clock edges with enable low are ignored
    @(negedge clk) bus_dat = 1'b1;
    for (int k = 0; k < 5; k++) begin
      gap(); bus_clk = 1'b1; gap(); bus_clk = 1'b0;
    end
    strobe();
    check_both("R2 idle clocks no load");
    send(29'h0246813, 28); strobe(); exp_l = 28'h0246813;
    check("R2 idle clocks not counted", got_l, exp_l);

    // R6: newer pending word overwrites older
    send(29'h0111111, 28);
    send(29'h0FEDCBA, 28);
    check("R6 held before strobe", got_l, exp_l);
    strobe(); exp_l = 28'h0FEDCBA;
    check("R6 newest applied", got_l, exp_l);
    strobe();
    check("R10 second strobe no change", got_l, exp_l);

    finish_run();
  end
endmodule